// File: doc/BRIEF.md
# General-Purpose Event SMI and Wake Gate

This block collects a bank of asynchronous general-purpose event lines and turns them into two system requests: a level-type system-management interrupt request and a resume (wake) request. Each line is synchronized, and its rising edge sets a sticky status bit. Software clears that bit by writing a one to it. Each event has its own enable bit that decides whether it can drive the SMI request. Each event also has its own sleep-disable bit that keeps it from waking the platform while a sleep state is in force.

Firmware reaches the three per-event registers through a small memory-mapped register port that sits in a 256-byte window. Register data is one bit per event. Bit N always serves event N. The SMI request ignores the sleep state and the sleep-disable mask. The wake request is honoured only while the sleep-state input is high. An event that is masked for wake can therefore still raise an SMI.

Top module: `evt_gate_ctrl`

## Requirements
- R1: After reset the status, enable and sleep-disable registers read zero, and `smi_req` and `wake_req` are low.
- R2: A rising edge on `evt_in[N]` sets status bit N on the third rising clock edge after the input changes (two synchronizer flops, then one edge register). Several lines may set their bits together. A line held high sets its bit only once.
- R3: A write to offset 0x10 clears every status bit written as 1 and leaves the bits written as 0 untouched.
- R4: If a new event edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x14 is read/write, and bit N enables event N. Only the low 24 bits exist.
- R6: `smi_req` is high exactly when some event has both its status bit and its enable bit set. Clearing the enable bit removes that event's contribution even though its status bit stays set.
- R7: The sleep-disable register at offset 0x18 is read/write, and bit N masks event N for wake.
- R8: `wake_req` is high exactly when `sleep_in` is high and some event has its status bit set while its sleep-disable bit is 0.
- R9: The sleep-disable mask and `sleep_in` have no effect on `smi_req`.
- R10: Read data appears on `bus_rdata` after the clock edge that samples the read strobe. Reads of unmapped offsets return zero, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| evt_in | input | 24 | Asynchronous general-purpose event lines |
| sleep_in | input | 1 | High while the system is in a sleep state |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 24 | Write data, one bit per event |
| bus_rdata | output | 24 | Registered read data |
| smi_req | output | 1 | Level SMI request |
| wake_req | output | 1 | Resume request, qualified by `sleep_in` |

## Verification
The interaction that matters is a synchronized event edge that sets a status bit in the same cycle that a firmware write clears that same bit. The bench first sets a bit. It then raises that event line again and times the clearing write so the write is sampled on exactly the edge where the status bit is set, and it expects the bit to stay set. A control case places the same write one cycle later and expects the bit to be cleared. Both cases run for every one of the 24 events.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SLPDIS = 8'h18;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_STATUS,
    RSEL_ENABLE,
    RSEL_SLPDIS
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_STATUS: s = RSEL_STATUS;
      OFS_ENABLE: s = RSEL_ENABLE;
      OFS_SLPDIS: s = RSEL_SLPDIS;
      default:    s = RSEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int unsigned N_EVT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_async,
  output logic [N_EVT-1:0] rise_o
);
  logic [N_EVT-1:0] meta_q;
  logic [N_EVT-1:0] sync_q;
  logic [N_EVT-1:0] prev_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= evt_async[i];
        sync_q[i] <= meta_q[i];
        prev_q[i] <= sync_q[i];
      end
    end

    assign rise_o[i] = sync_q[i] & ~prev_q[i];

    // R2: an edge indication lasts exactly one cycle
    p_rise_single_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned N_EVT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] stat_o
);
  logic [N_EVT-1:0] stat_q;

  // set has priority over clear when both hit one bit
  function automatic logic [N_EVT-1:0] next_status(
    input logic [N_EVT-1:0] cur,
    input logic [N_EVT-1:0] set,
    input logic [N_EVT-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= next_status(stat_q, set_i, clr_i);
  end

  assign stat_o = stat_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_chk
    p_set_on_rise_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> stat_o[i]);
    p_w1c_clears_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !stat_o[i]);
    p_hold_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(stat_o[i]));
    p_set_wins_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && set_i[i]) |=> stat_o[i]);
  end
endmodule

// File: rtl/evt_reg_if.sv
module evt_reg_if
  import evt_gate_pkg::*;
#(
  parameter int unsigned N_EVT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_EVT-1:0]  bus_wdata,
  input  logic [N_EVT-1:0]  stat_i,
  output logic [N_EVT-1:0]  rdata_o,
  output logic [N_EVT-1:0]  enable_o,
  output logic [N_EVT-1:0]  slpdis_o,
  output logic [N_EVT-1:0]  clr_o
);
  reg_sel_e         sel;
  logic             wr_hit;
  logic             rd_hit;
  logic [N_EVT-1:0] enable_q;
  logic [N_EVT-1:0] slpdis_q;
  logic [N_EVT-1:0] rdata_q;
  logic [N_EVT-1:0] rd_mux;

  assign sel    = decode_offset(bus_addr);
  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;

  assign clr_o = (wr_hit && sel == RSEL_STATUS) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      slpdis_q <= '0;
    end else if (wr_hit) begin
      if (sel == RSEL_ENABLE) enable_q <= bus_wdata;
      if (sel == RSEL_SLPDIS) slpdis_q <= bus_wdata;
    end
  end

  always_comb begin
    case (sel)
      RSEL_STATUS: rd_mux = stat_i;
      RSEL_ENABLE: rd_mux = enable_q;
      RSEL_SLPDIS: rd_mux = slpdis_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign enable_o = enable_q;
  assign slpdis_o = slpdis_q;

  p_enable_write_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_ENABLE) |=> enable_o == $past(bus_wdata));
  p_slpdis_write_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_SLPDIS) |=> slpdis_o == $past(bus_wdata));
  p_unmapped_read_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr != OFS_STATUS && bus_addr != OFS_ENABLE
     && bus_addr != OFS_SLPDIS) |=> rdata_o == '0);
  p_unmapped_write_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr != OFS_ENABLE && bus_addr != OFS_SLPDIS)
    |=> ($stable(enable_o) && $stable(slpdis_o)));
endmodule

// File: rtl/evt_gate_ctrl.sv
module evt_gate_ctrl
  import evt_gate_pkg::*;
#(
  parameter int unsigned N_EVT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic              sleep_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_EVT-1:0]  bus_wdata,
  output logic [N_EVT-1:0]  bus_rdata,
  output logic              smi_req,
  output logic              wake_req
);
  logic [N_EVT-1:0] evt_rise;
  logic [N_EVT-1:0] status;
  logic [N_EVT-1:0] enable;
  logic [N_EVT-1:0] slpdis;
  logic [N_EVT-1:0] w1c_clear;
  logic [N_EVT-1:0] smi_hits;
  logic [N_EVT-1:0] wake_hits;

  function automatic logic [N_EVT-1:0] gate_vec(
    input logic [N_EVT-1:0] st,
    input logic [N_EVT-1:0] pass
  );
    return st & pass;
  endfunction

  evt_sync_edge #(.N_EVT(N_EVT)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_async (evt_in),
    .rise_o    (evt_rise)
  );

  evt_status_bank #(.N_EVT(N_EVT)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_rise),
    .clr_i  (w1c_clear),
    .stat_o (status)
  );

  evt_reg_if #(.N_EVT(N_EVT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat_i    (status),
    .rdata_o   (bus_rdata),
    .enable_o  (enable),
    .slpdis_o  (slpdis),
    .clr_o     (w1c_clear)
  );

  assign smi_hits  = gate_vec(status, enable);
  assign wake_hits = gate_vec(status, ~slpdis);
  assign smi_req   = |smi_hits;
  assign wake_req  = sleep_in & (|wake_hits);

  p_smi_needs_enable_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !smi_req);
  p_smi_needs_status_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !smi_req);
  p_wake_needs_sleep_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_in |-> !wake_req);
  p_wake_all_masked_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (slpdis == '1) |-> !wake_req);
endmodule

// File: tb/evt_gate_ctrl_tb.sv
`timescale 1ns/1ps
module evt_gate_ctrl_tb;
  localparam int N = 24;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_in = '0;
  logic         sleep_in = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         smi_req;
  logic         wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_gate_ctrl #(.N_EVT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sleep_in(sleep_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smi_req(smi_req), .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // raise lines, hold four cycles, drop them
  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    evt_in = evt_in | m;
    repeat (4) @(negedge clk);
    evt_in = evt_in & ~m;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic any_and(input logic [N-1:0] a, input logic [N-1:0] b);
    for (int k = 0; k < N; k++) if (a[k] && b[k]) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    logic [N-1:0] bit_i;
    logic [N-1:0] en;
    logic [N-1:0] msk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h10, d); check("R1 status", d, 0);
    rd(8'h14, d); check("R1 enable", d, 0);
    rd(8'h18, d); check("R1 slpdis", d, 0);
    check("R1 smi", smi_req, 0);
    check("R1 wake", wake_req, 0);

    // R5 / R7 register readback
    wr(8'h14, 24'hA5C33C); rd(8'h14, d); check("R5 enable rw", d, 24'hA5C33C);
    wr(8'h18, 24'h0F0F55); rd(8'h18, d); check("R7 slpdis rw", d, 24'h0F0F55);
    // R10 unmapped access
    wr(8'h1C, ALL); wr(8'h00, ALL);
    rd(8'h14, d); check("R10 enable kept", d, 24'hA5C33C);
    rd(8'h18, d); check("R10 slpdis kept", d, 24'h0F0F55);
    rd(8'h1C, d); check("R10 unmapped rd", d, 0);
    rd(8'hFF, d); check("R10 unmapped rd hi", d, 0);

    // R2 several lines together
    wr(8'h14, '0); wr(8'h18, '0);
    pulse(24'hA5A5A5);
    rd(8'h10, d); check("R2 multi set", d, 24'hA5A5A5);
    check("R6 no enable no smi", smi_req, 0);
    wr(8'h10, ALL);
    rd(8'h10, d); check("R3 clear all", d, 0);

    // R2 held level sets once
    @(negedge clk); evt_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    wr(8'h10, 24'h000008);
    repeat (6) @(negedge clk);
    rd(8'h10, d); check("R2 held level no reset", d, 0);
    @(negedge clk); evt_in[3] = 1'b0;
    repeat (4) @(negedge clk);

    // R2 latency: third edge after the change
    @(negedge clk); evt_in[7] = 1'b1;
    @(negedge clk); check("R2 latency e1", smi_req, 0);
    wr(8'h14, ALL);            // takes one more edge
    check("R2 latency e3", u_dut.bus_rdata === bus_rdata ? smi_req : 1'b0, 1);
    @(negedge clk); evt_in[7] = 1'b0;
    repeat (3) @(negedge clk);
    wr(8'h10, ALL);

    // per-event sweep
    for (int i = 0; i < N; i++) begin
      bit_i = '0; bit_i[i] = 1'b1;
      en = ALL; msk = '0;
      wr(8'h14, en); wr(8'h18, msk); sleep_in = 1'b0;
      pulse(bit_i);
      rd(8'h10, d); check($sformatf("R2 ev%0d set", i), d, bit_i);
      check($sformatf("R6 ev%0d smi", i), smi_req, any_and(d, en));
      check($sformatf("R8 ev%0d awake no wake", i), wake_req, 0);
      @(negedge clk); sleep_in = 1'b1; #1;
      check($sformatf("R8 ev%0d wake", i), wake_req, any_and(d, ~msk));
      msk = bit_i; wr(8'h18, msk);
      check($sformatf("R8 ev%0d masked", i), wake_req, any_and(d, ~msk));
      check($sformatf("R9 ev%0d smi masked", i), smi_req, 1);
      en = ALL & ~bit_i; wr(8'h14, en);
      check($sformatf("R6 ev%0d disabled", i), smi_req, any_and(d, en));
      wr(8'h14, ALL);
      wr(8'h10, ~bit_i);
      rd(8'h10, d); check($sformatf("R3 ev%0d zeros keep", i), d, bit_i);
      wr(8'h10, bit_i);
      rd(8'h10, d); check($sformatf("R3 ev%0d cleared", i), d, 0);
      check($sformatf("R6 ev%0d smi drop", i), smi_req, 0);
      sleep_in = 1'b0;
    end

    // R4 set and clear collide, with a one-cycle-late control
    wr(8'h18, '0);
    for (int i = 0; i < N; i++) begin
      bit_i = '0; bit_i[i] = 1'b1;
      pulse(bit_i);
      @(negedge clk); evt_in = bit_i;      // change before edge P1
      @(negedge clk);                      // after P1
      @(negedge clk);                      // after P2, rise seen
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = bit_i;
      @(negedge clk);                      // P3: set and clear together
      bus_sel = 1'b0; bus_wr = 1'b0;
      rd(8'h10, d); check($sformatf("R4 ev%0d set wins", i), d, bit_i);
      wr(8'h10, bit_i);
      rd(8'h10, d); check($sformatf("R3 ev%0d late clear", i), d, 0);
      @(negedge clk); evt_in = '0;
      repeat (3) @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule